// File: doc/BRIEF.md
# Parallel NOR Flash Bank Eraser and Programmer

This block erases or programs one bank of a byte-wide parallel NOR flash and then reads the whole bank back to confirm the result. A host raises `start` for one cycle together with an opcode (erase or program), a command-set select and a bank number. The block then runs the flash bus on its own until it pulses `done` with a two-bit result code. For a program job the bytes come from a source buffer, which the block reads through an address/data port with one cycle of read latency.

Two command sets are built in. The status-register set writes a two-byte command, then polls by writing a status-read command and reading the status byte until the ready bit comes up. It finishes each job with a clear-status write and a return-to-array write. The unlock set opens every command with a fixed pair of writes to two magic offsets inside the bank. It polls completion by reading the bank base twice in a row and comparing the toggle bit. Every polling loop has a fixed limit on the number of attempts. The bank base address is the bank index times the bank size.

Top module: `flashprog`

## Requirements
- R1: Out of reset `busy` and `done` are low, and `flash_we`, `flash_re` and `src_re` stay low for as long as the block is idle.
- R2: In status mode (`mode`=0), an erase (`op`=0) writes 0x20 and then 0xD0 to the bank base. It then repeats a write of 0x70 to the base followed by a read of the base until the status byte has bit 7 set.
- R3: In status mode, programming byte i writes 0x40 and then the data byte to bank offset i, then polls as in R2. After each poll that completes, the block writes 0x50 and then 0xFF to the bank base.
- R4: In status mode, a completed status byte with any bit of mask 0x38 set makes the job end, after the 0x50/0xFF writes and without a verify pass, with `result`=3.
- R5: In unlock mode (`mode`=1), an erase writes AA to offset UNLOCK_A, 55 to UNLOCK_B, 80 to UNLOCK_A, AA to UNLOCK_A, 55 to UNLOCK_B, and then ERASE_CMD (default 0x30) to the bank base, in that order.
- R6: In unlock mode, programming byte i writes AA to UNLOCK_A, 55 to UNLOCK_B and A0 to UNLOCK_A, and then the data byte to bank offset i.
- R7: In unlock mode, completion is found by two back-to-back reads of the bank base. The operation is finished when bit 6 is equal in both reads; otherwise the pair of reads is repeated.
- R8: A polling loop that sees POLL_LIMIT attempts in a row without completion ends the job with `result`=1 and no verify pass.
- R9: After a successful erase, the block reads every bank offset from 0 upward and expects 0xFF; after a program it expects the source byte at the same index. The first mismatch ends the job with `result`=2; a clean pass gives `result`=0.
- R10: Every flash address equals bank × BANK_BYTES plus an offset below BANK_BYTES, for the bank latched at start.
- R11: `busy` rises in the cycle after an accepted start and stays high up to and including the single-cycle `done` pulse. A `start` seen while busy is ignored.
- R12: `flash_we` and `flash_re` are never high together, and `src_re` is raised only during program jobs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle job request, taken only when idle |
| op | input | 1 | 0 erase, 1 program |
| mode | input | 1 | 0 status-register commands, 1 unlock/toggle commands |
| bank | input | SEL_W | Bank index |
| busy | output | 1 | High from acceptance through the done pulse |
| done | output | 1 | One-cycle end-of-job pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 verify mismatch, 3 device error; valid with done |
| src_re | output | 1 | Source buffer read strobe |
| src_addr | output | OFF_W | Source buffer byte index |
| src_rdata | input | 8 | Source byte, valid the cycle after src_re |
| flash_addr | output | FA_W | Flash byte address |
| flash_wdata | output | 8 | Flash write data |
| flash_we | output | 1 | Flash write strobe |
| flash_re | output | 1 | Flash read strobe |
| flash_rdata | input | 8 | Flash read data, valid the cycle after flash_re |

## Verification
The assertions assume that `start` is only taken while the block is idle. They also assume that the flash and source ports return data exactly one cycle after each read strobe. The bench meets both: its flash and buffer models register their read data on the strobe edge, and it drives every request a half cycle away from the active edge. The bench also pulses `start` once during a running job, to show that the block drops the request instead of relying on the host to hold back.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_TIMEOUT = 2'd1,
      RES_VERIFY  = 2'd2,
      RES_DEVICE  = 2'd3
   } fp_result_e;

   typedef enum logic [4:0] {
      ST_IDLE, ST_FETCH, ST_LOAD, ST_UNLOCK, ST_TDATA,
      ST_SCMD1, ST_SCMD2, ST_SPOLLW, ST_SPOLLR, ST_SCHK, ST_SCLR, ST_SRST,
      ST_TPOLL1, ST_TPOLL2, ST_TCHK, ST_VREQ, ST_VCHK, ST_DONE
   } fp_state_e;

   localparam logic [7:0] SC_ERASE_SETUP = 8'h20;
   localparam logic [7:0] SC_ERASE_GO    = 8'hD0;
   localparam logic [7:0] SC_PROG_SETUP  = 8'h40;
   localparam logic [7:0] SC_STAT_READ   = 8'h70;
   localparam logic [7:0] SC_STAT_CLEAR  = 8'h50;
   localparam logic [7:0] SC_ARRAY_MODE  = 8'hFF;
   localparam logic [7:0] SC_READY_BIT   = 8'h80;
   localparam logic [7:0] SC_FAIL_MASK   = 8'h38;
   localparam logic [7:0] TG_TOGGLE_MASK = 8'h40;
   localparam logic [7:0] ERASED_BYTE    = 8'hFF;

endpackage

// File: rtl/flashprog_poll_timer.sv
module flashprog_poll_timer #(
   parameter int LIMIT = 1000000,
   localparam int CW = $clog2(LIMIT + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else if (step)     cnt_q <= cnt_q + 1'b1;
   end

   // the attempt that would make the count reach LIMIT ends the loop
   assign expired = step && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/flashprog_idx.sv
module flashprog_idx #(
   parameter int DEPTH = 8192,
   localparam int IW = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [IW-1:0] idx,
   output logic          last
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) idx <= '0;
      else if (inc)      idx <= idx + 1'b1;
   end

   assign last = (idx == IW'(DEPTH - 1));
endmodule

// File: rtl/flashprog_unlock.sv
module flashprog_unlock #(
   parameter int         OFF_W     = 13,
   parameter int         UNLOCK_A  = 'h555,
   parameter int         UNLOCK_B  = 'h2AA,
   parameter logic [7:0] ERASE_CMD = 8'h30
)(
   input  logic             prog,
   input  logic [2:0]       step,
   output logic [OFF_W-1:0] off,
   output logic [7:0]       data,
   output logic             last
);
   always_comb begin
      off  = OFF_W'(UNLOCK_A);
      data = 8'hAA;
      last = 1'b0;
      case (step)
         3'd0: ;
         3'd1: begin off = OFF_W'(UNLOCK_B); data = 8'h55; end
         3'd2: begin data = prog ? 8'hA0 : 8'h80; last = prog; end
         3'd3: ;
         3'd4: begin off = OFF_W'(UNLOCK_B); data = 8'h55; end
         default: begin off = '0; data = ERASE_CMD; last = 1'b1; end
      endcase
   end
endmodule

// File: rtl/flashprog.sv
module flashprog import flashprog_pkg::*; #(
   parameter int         BANK_BYTES = 8192,
   parameter int         BANKS      = 2,
   parameter int         POLL_LIMIT = 1000000,
   parameter int         UNLOCK_A   = 'h555,
   parameter int         UNLOCK_B   = 'h2AA,
   parameter logic [7:0] ERASE_CMD  = 8'h30,
   localparam int OFF_W = $clog2(BANK_BYTES),
   localparam int SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1,
   localparam int FA_W  = OFF_W + ((BANKS > 1) ? $clog2(BANKS) : 0)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             op,
   input  logic             mode,
   input  logic [SEL_W-1:0] bank,
   output logic             busy,
   output logic             done,
   output logic [1:0]       result,
   output logic             src_re,
   output logic [OFF_W-1:0] src_addr,
   input  logic [7:0]       src_rdata,
   output logic [FA_W-1:0]  flash_addr,
   output logic [7:0]       flash_wdata,
   output logic             flash_we,
   output logic             flash_re,
   input  logic [7:0]       flash_rdata
);
   if (BANK_BYTES < 2 || (BANK_BYTES & (BANK_BYTES - 1)) != 0) begin : g_bad_size
      $error("BANK_BYTES must be a power of two");
   end
   if (UNLOCK_A >= BANK_BYTES || UNLOCK_B >= BANK_BYTES) begin : g_bad_unlock
      $error("unlock offsets must lie inside one bank");
   end
   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("POLL_LIMIT must be at least one");
   end

   fp_state_e        state_q, nxt;
   logic             prog_q, tog_q;
   logic [SEL_W-1:0] bank_q;
   logic [7:0]       dbyte_q, first_q;
   logic [2:0]       step_q;
   logic             dev_err_q;
   fp_result_e       res_q, res_nxt;
   logic             idx_clr, idx_inc, idx_last, adv, poll_step, expired;
   logic [OFF_W-1:0] idx, ul_off, off_sel;
   logic [7:0]       ul_data;
   logic             ul_last, toggling, ready;

   flashprog_idx #(.DEPTH(BANK_BYTES)) u_idx (
      .clk(clk), .rst_n(rst_n), .clr(idx_clr), .inc(idx_inc), .idx(idx), .last(idx_last));

   flashprog_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(!(state_q inside {ST_SPOLLW, ST_SPOLLR, ST_SCHK,
                                        ST_TPOLL1, ST_TPOLL2, ST_TCHK})),
      .step(poll_step), .expired(expired));

   flashprog_unlock #(.OFF_W(OFF_W), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B),
                      .ERASE_CMD(ERASE_CMD)) u_unlock (
      .prog(prog_q), .step(step_q), .off(ul_off), .data(ul_data), .last(ul_last));

   assign ready     = (flash_rdata & SC_READY_BIT) != 8'h00;
   assign toggling  = ((first_q ^ flash_rdata) & TG_TOGGLE_MASK) != 8'h00;
   assign poll_step = (state_q == ST_SCHK && !ready) || (state_q == ST_TCHK && toggling);

   // next state
   always_comb begin
      nxt = state_q; res_nxt = RES_OK; adv = 1'b0;
      idx_clr = 1'b0; idx_inc = 1'b0;
      case (state_q)
         ST_IDLE:   if (start) begin
                       idx_clr = 1'b1;
                       nxt = op ? ST_FETCH : (mode ? ST_UNLOCK : ST_SCMD1);
                    end
         ST_FETCH:  nxt = ST_LOAD;
         ST_LOAD:   nxt = tog_q ? ST_UNLOCK : ST_SCMD1;
         ST_UNLOCK: if (ul_last) nxt = prog_q ? ST_TDATA : ST_TPOLL1;
         ST_TDATA:  nxt = ST_TPOLL1;
         ST_SCMD1:  nxt = ST_SCMD2;
         ST_SCMD2:  nxt = ST_SPOLLW;
         ST_SPOLLW: nxt = ST_SPOLLR;
         ST_SPOLLR: nxt = ST_SCHK;
         ST_SCHK:   if (ready) nxt = ST_SCLR;
                    else if (expired) begin nxt = ST_DONE; res_nxt = RES_TIMEOUT; end
                    else nxt = ST_SPOLLW;
         ST_SCLR:   nxt = ST_SRST;
         ST_SRST:   if (dev_err_q) begin nxt = ST_DONE; res_nxt = RES_DEVICE; end
                    else adv = 1'b1;
         ST_TPOLL1: nxt = ST_TPOLL2;
         ST_TPOLL2: nxt = ST_TCHK;
         ST_TCHK:   if (!toggling) adv = 1'b1;
                    else if (expired) begin nxt = ST_DONE; res_nxt = RES_TIMEOUT; end
                    else nxt = ST_TPOLL1;
         ST_VREQ:   nxt = ST_VCHK;
         ST_VCHK:   if (flash_rdata != (prog_q ? src_rdata : ERASED_BYTE)) begin
                       nxt = ST_DONE; res_nxt = RES_VERIFY;
                    end else if (idx_last) nxt = ST_DONE;
                    else begin nxt = ST_VREQ; idx_inc = 1'b1; end
         ST_DONE:   nxt = ST_IDLE;
         default:   nxt = ST_IDLE;
      endcase
      if (adv) begin
         if (!prog_q || idx_last) begin nxt = ST_VREQ; idx_clr = 1'b1; end
         else begin nxt = ST_FETCH; idx_inc = 1'b1; end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE; prog_q <= 1'b0; tog_q <= 1'b0; bank_q <= '0;
         dbyte_q <= '0; first_q <= '0; step_q <= '0; dev_err_q <= 1'b0; res_q <= RES_OK;
      end else begin
         state_q <= nxt;
         if (state_q == ST_IDLE && start) begin
            prog_q <= op; tog_q <= mode; bank_q <= bank; dev_err_q <= 1'b0; step_q <= '0;
         end
         if (state_q == ST_LOAD)   begin dbyte_q <= src_rdata; step_q <= '0; end
         if (state_q == ST_UNLOCK) step_q <= step_q + 1'b1;
         if (state_q == ST_TPOLL2) first_q <= flash_rdata;
         if (state_q == ST_SCHK && ready)
            dev_err_q <= (flash_rdata & SC_FAIL_MASK) != 8'h00;
         if (nxt == ST_DONE && state_q != ST_DONE) res_q <= res_nxt;
      end
   end

   // bus drive
   always_comb begin
      flash_we = 1'b0; flash_re = 1'b0; flash_wdata = 8'h00; off_sel = '0; src_re = 1'b0;
      case (state_q)
         ST_FETCH:  src_re = 1'b1;
         ST_UNLOCK: begin flash_we = 1'b1; off_sel = ul_off; flash_wdata = ul_data; end
         ST_TDATA:  begin flash_we = 1'b1; off_sel = idx; flash_wdata = dbyte_q; end
         ST_SCMD1:  begin flash_we = 1'b1; off_sel = prog_q ? idx : '0;
                          flash_wdata = prog_q ? SC_PROG_SETUP : SC_ERASE_SETUP; end
         ST_SCMD2:  begin flash_we = 1'b1; off_sel = prog_q ? idx : '0;
                          flash_wdata = prog_q ? dbyte_q : SC_ERASE_GO; end
         ST_SPOLLW: begin flash_we = 1'b1; flash_wdata = SC_STAT_READ; end
         ST_SCLR:   begin flash_we = 1'b1; flash_wdata = SC_STAT_CLEAR; end
         ST_SRST:   begin flash_we = 1'b1; flash_wdata = SC_ARRAY_MODE; end
         ST_SPOLLR, ST_TPOLL1, ST_TPOLL2: flash_re = 1'b1;
         ST_VREQ:   begin flash_re = 1'b1; off_sel = idx; src_re = prog_q; end
         default: ;
      endcase
   end

   if (BANKS > 1) begin : g_multi_bank
      assign flash_addr = {bank_q, off_sel};
   end else begin : g_single_bank
      assign flash_addr = off_sel;
   end

   assign src_addr = idx;
   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_DONE);
   assign result   = res_q;
endmodule

// File: rtl/flashprog_chk.sv
module flashprog_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic flash_we,
   input logic flash_re,
   input logic src_re
);
   p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(flash_we || flash_re || src_re));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(flash_we && flash_re));

   p_src_in_job_r12: assert property (@(posedge clk) disable iff (!rst_n)
      src_re |-> busy);
endmodule

bind flashprog flashprog_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .flash_we(flash_we), .flash_re(flash_re), .src_re(src_re));

// File: tb/flashprog_bench.sv
module flashprog_bench;
   localparam int CLK_PERIOD = 10;
   localparam int BB = 64;
   localparam int NB = 2;
   localparam int PL = 8;
   localparam int UA = 'h15;
   localparam int UB = 'h2A;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, op = 1'b0, mode = 1'b0;
   logic [0:0] bank = '0;
   logic busy, done, src_re, flash_we, flash_re;
   logic [1:0] result;
   logic [5:0] src_addr;
   logic [7:0] src_rdata = '0, flash_wdata, flash_rdata = '0;
   logic [6:0] flash_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   flashprog #(.BANK_BYTES(BB), .BANKS(NB), .POLL_LIMIT(PL),
               .UNLOCK_A(UA), .UNLOCK_B(UB)) u_flashprog (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mode(mode), .bank(bank),
      .busy(busy), .done(done), .result(result), .src_re(src_re), .src_addr(src_addr),
      .src_rdata(src_rdata), .flash_addr(flash_addr), .flash_wdata(flash_wdata),
      .flash_we(flash_we), .flash_re(flash_re), .flash_rdata(flash_rdata));

   int compared = 0, mismatched = 0;

   task automatic chk(string req, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // flash and source models
   logic [7:0] mem [NB*BB];
   logic [7:0] src [BB];
   int  cur_mode = 0, cur_bank = 0, cur_op = 0;
   int  busy_len = 1, busy_left = 0, err_bits = 0, bad_addr = -1;
   bit  stuck = 0, stat_rd = 0, tg_toggle = 0, tg_prog = 0;
   int  sm_pend = 0, tg_step = 0;
   int  reads = 0, oob = 0, both_cnt = 0, src_bad = 0;
   int  log_a[$], log_d[$];

   always @(posedge clk) begin
      int a, o, d;
      a = int'(flash_addr); o = a % BB; d = int'(flash_wdata);
      if (src_re) begin
         src_rdata <= src[src_addr];
         if (cur_op == 0) src_bad++;
      end
      if (flash_we && flash_re) both_cnt++;
      if ((flash_we || flash_re) && (a / BB) != cur_bank) oob++;
      if (flash_we) begin
         log_a.push_back(a); log_d.push_back(d);
         if (cur_mode == 0) begin
            if (sm_pend == 1 && d == 'hD0) begin
               for (int i = 0; i < BB; i++) mem[(a/BB)*BB + i] = 8'hFF;
               busy_left = busy_len; sm_pend = 0; stat_rd = 1;
            end else if (sm_pend == 2) begin
               mem[a] = flash_wdata ^ ((a == bad_addr) ? 8'h01 : 8'h00);
               busy_left = busy_len; sm_pend = 0; stat_rd = 1;
            end else begin
               case (d)
                  'h20: sm_pend = 1;
                  'h40: sm_pend = 2;
                  'h70: stat_rd = 1;
                  'hFF: stat_rd = 0;
                  default: ;
               endcase
            end
         end else if (tg_prog) begin
            mem[a] = flash_wdata ^ ((a == bad_addr) ? 8'h01 : 8'h00);
            busy_left = busy_len; tg_prog = 0;
         end else begin
            case (tg_step)
               0: tg_step = (o == UA && d == 'hAA) ? 1 : 0;
               1: tg_step = (o == UB && d == 'h55) ? 2 : 0;
               2: begin
                     if (o == UA && d == 'hA0) tg_prog = 1;
                     tg_step = (o == UA && d == 'h80) ? 3 : 0;
                  end
               3: tg_step = (o == UA && d == 'hAA) ? 4 : 0;
               4: tg_step = (o == UB && d == 'h55) ? 5 : 0;
               default: begin
                     if (d == 'h30) begin
                        for (int i = 0; i < BB; i++) mem[(a/BB)*BB + i] = 8'hFF;
                        busy_left = busy_len;
                     end
                     tg_step = 0;
                  end
            endcase
         end
      end
      if (flash_re) begin
         reads++;
         if (busy_left > 0 || stuck) begin
            if (busy_left > 0) busy_left--;
            tg_toggle = !tg_toggle;
            if (cur_mode == 0) flash_rdata <= 8'h00;
            else flash_rdata <= {1'b0, tg_toggle, 6'b0};
         end else if (cur_mode == 0 && stat_rd)
            flash_rdata <= 8'h80 | 8'(err_bits);
         else
            flash_rdata <= mem[a];
      end
   end

   // scoreboard
   logic [1:0] exp_q[$];
   string      tag_q[$];

   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) chk("R11 unexpected done", 1, 0);
         else begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            chk(t, int'(result), int'(e));
         end
      end
   end

   task automatic run_op(int o, int m, int b, logic [1:0] exp_res, string tag);
      exp_q.push_back(exp_res); tag_q.push_back(tag);
      log_a.delete(); log_d.delete(); reads = 0;
      cur_op = o; cur_mode = m; cur_bank = b; tg_step = 0; tg_prog = 0; sm_pend = 0;
      @(negedge clk);
      op = o[0]; mode = m[0]; bank = b[0]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   function automatic int bank_diff(int b, bit erased);
      int n = 0;
      for (int i = 0; i < BB; i++)
         if (mem[b*BB + i] != (erased ? 8'hFF : src[i])) n++;
      return n;
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int n, j;
      for (int i = 0; i < BB; i++) src[i] = 8'((i * 7 + 3) ^ 'h5A);
      for (int i = 0; i < NB*BB; i++) mem[i] = 8'h11;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset busy/done", {busy, done}, 0);
      chk("R1 reset strobes", {flash_we, flash_re, src_re}, 0);

      // R2 status erase of bank 1
      busy_len = 3;
      run_op(0, 0, 1, 2'd0, "R2 status erase result");
      chk("R2 first cmd", log_a[0]*256 + log_d[0], 64*256 + 'h20);
      chk("R2 confirm cmd", log_a[1]*256 + log_d[1], 64*256 + 'hD0);
      chk("R2 status read cmd", log_a[2]*256 + log_d[2], 64*256 + 'h70);
      chk("R2 poll+verify reads", reads, 4 + BB);
      chk("R9 erased bank all FF", bank_diff(1, 1), 0);
      n = 0; for (int i = 0; i < BB; i++) if (mem[i] != 8'h11) n++;
      chk("R10 other bank untouched", n, 0);

      // R3 status program of bank 1
      busy_len = 2;
      run_op(1, 0, 1, 2'd0, "R3 status program result");
      chk("R3 setup cmd", log_a[0]*256 + log_d[0], 64*256 + 'h40);
      chk("R3 data write", log_a[1]*256 + log_d[1], 64*256 + int'(src[0]));
      j = 0; while (j < log_d.size() && log_d[j] != 'h50) j++;
      chk("R3 reset after clear", log_d[j+1], 'hFF);
      chk("R3 poll+verify reads", reads, BB*3 + BB);
      chk("R9 programmed bank matches", bank_diff(1, 0), 0);

      // R4 status error bits
      busy_len = 1; err_bits = 'h10;
      run_op(0, 0, 0, 2'd3, "R4 device error result");
      err_bits = 0;
      chk("R4 no verify reads", reads, 2);
      chk("R4 clear then reset", log_d[log_d.size()-2]*256 + log_d[log_d.size()-1], 'h50FF);

      // R5/R7 unlock erase of bank 0
      busy_len = 2;
      run_op(0, 1, 0, 2'd0, "R5 unlock erase result");
      begin
         int ea[6] = '{UA, UB, UA, UA, UB, 0};
         int ed[6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h30};
         n = 0;
         for (int i = 0; i < 6; i++) if (log_a[i] != ea[i] || log_d[i] != ed[i]) n++;
         chk("R5 six-cycle erase sequence", n, 0);
      end
      chk("R7 toggle pairs + verify reads", reads, 4 + BB);
      chk("R9 unlock erased all FF", bank_diff(0, 1), 0);

      // R6 unlock program of bank 0
      run_op(1, 1, 0, 2'd0, "R6 unlock program result");
      chk("R6 unlock 1", log_a[0]*256 + log_d[0], UA*256 + 'hAA);
      chk("R6 unlock 2", log_a[1]*256 + log_d[1], UB*256 + 'h55);
      chk("R6 program cmd", log_a[2]*256 + log_d[2], UA*256 + 'hA0);
      chk("R6 data write", log_a[3]*256 + log_d[3], int'(src[0]));
      chk("R7 reads per byte", reads, BB*4 + BB);
      chk("R9 unlock programmed matches", bank_diff(0, 0), 0);

      // R11 start while busy is dropped
      exp_q.push_back(2'd0); tag_q.push_back("R11 erase with stray start");
      cur_op = 0; cur_mode = 1; cur_bank = 1; tg_step = 0; tg_prog = 0;
      @(negedge clk); op = 1'b0; mode = 1'b1; bank = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (4) @(negedge clk);
      op = 1'b1; mode = 1'b0; bank = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R11 busy after stray start", busy, 1);
      while (!done) @(negedge clk);
      repeat (6) @(negedge clk);
      chk("R11 no second job", {busy, 7'(exp_q.size())}, 0);
      chk("R11 bank 0 untouched", bank_diff(0, 0), 0);

      // R8 timeouts
      stuck = 1;
      run_op(0, 0, 1, 2'd1, "R8 status timeout result");
      chk("R8 status poll attempts", reads, PL);
      run_op(0, 1, 1, 2'd1, "R8 unlock timeout result");
      chk("R8 toggle poll reads", reads, 2*PL);
      stuck = 0;

      // R9 verify mismatch at offset 37 of bank 1
      busy_len = 1; bad_addr = BB + 37;
      run_op(1, 0, 1, 2'd2, "R9 verify mismatch result");
      chk("R9 verify stops at mismatch", reads, BB*2 + 38);
      bad_addr = -1;

      chk("R10 accesses outside bank", oob, 0);
      chk("R12 write and read together", both_cnt, 0);
      chk("R12 source read during erase", src_bad, 0);
      finish_run();
   end
endmodule